// File: doc/BRIEF.md
# Two-Channel Byte-Port DAC Write Sequencer

This block feeds an external dual-channel DAC whose channels are 12 bits wide but whose data port carries only 8 bits. When a frame strobe arrives (once per millisecond in the intended system), the block captures one 12-bit word for each channel. It then breaks each word into a low byte and a high nibble and writes the four pieces into the converter's addressed input latches, one chip-select pulse per piece. After the last piece, a single load pulse moves both channels' input latches into their output latches, so the two analog outputs change together.

Channel 1 is intended for a bipolar control effort that drives a unipolar 0-10 V motor input. Its word is taken as a signed two's-complement code and converted to offset binary by adding 2048, so a zero command lands at mid-scale, which means stop. Which channels get this conversion is a parameter. The address and data lines settle a set number of cycles before each chip-select pulse and stay put for a set number of cycles after it. While a sequence runs, the block ignores further strobes and raises a busy flag.

Top module: `dac_pair_sequencer`

## Requirements
- R1: After reset, dac_cs_n and dac_ldac_n are high, busy is low, and the address lines and dac_data are zero.
- R2: A frame_stb seen while the block is idle captures both words. Busy is high from the next cycle for 4*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+1 cycles, which is 13 with the defaults. While busy is low, the chip-select and load lines stay high.
- R3: Within a frame there are exactly four chip-select pulses, written in this order: address {a1,a0}=00 takes channel-0 bits 7:0, 01 takes channel-0 bits 11:8, 10 takes channel-1 bits 7:0, and 11 takes channel-1 bits 11:8.
- R4: When the high nibble is written (a0=1), it appears on dac_data[3:0] and dac_data[7:4] is zero.
- R5: Each chip-select low pulse lasts STROBE_CYC cycles. Address and data are valid for SETUP_CYC cycles before the pulse and do not change while it is low or for HOLD_CYC cycles after it rises.
- R6: dac_ldac_n goes low for exactly one cycle, starting the cycle after the fourth write's hold period. It never overlaps a chip-select pulse.
- R7: A frame_stb that arrives while a sequence runs has no effect. The running frame is not restarted, and the words it carries are not written.
- R8: For a channel whose bit is set in OFFSET_MASK (default: channel 1 only), the written 12-bit code is the input plus 2048 modulo 4096. Other channels are written unchanged.
- R9: Changes on ch0_word or ch1_word after the capture cycle do not alter the bytes of the frame in progress.
- R10: A frame_stb present in the load-pulse cycle starts the next frame right after it. Busy stays high and the new words are written with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Start-of-frame request, one cycle |
| ch0_word | input | 12 | Channel-0 sample |
| ch1_word | input | 12 | Channel-1 sample |
| dac_data | output | 8 | Byte to the converter's data port |
| dac_a1 | output | 1 | Input-latch select, upper bit |
| dac_a0 | output | 1 | Input-latch select, lower bit (1 = high nibble) |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_ldac_n | output | 1 | Load both output latches, active low |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest cases to reach are the one-cycle window where a strobe coincides with the load pulse and the moment right after capture when the input words change. Both depend on where a strobe falls within a 13-cycle frame. The stimulus holds frame_stb high across a whole frame while swapping the words one cycle after capture. This puts a strobe in every busy cycle, including the load cycle, and shows whether the captured words are replaced early or whether the gapless restart happens. A behavioural model that lays out the expected output stream for each accepted strobe is compared on every cycle. Signed extremes (-1, -2048, +2047) exercise the offset conversion.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STRB  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_LOAD  = 3'd4
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dac_reset_sync.sv
module dac_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len_m1,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q == len_m1);
  assign cnt_en = restart || !done;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)    cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_word_latch.sv
module dac_word_latch #(
  parameter int          NUM_CH      = 2,
  parameter int          SAMPLE_W    = 12,
  parameter logic [NUM_CH-1:0] OFFSET_MASK = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NUM_CH*SAMPLE_W-1:0]   words_in,
  output logic [NUM_CH*SAMPLE_W-1:0]   words_q,
  output logic [NUM_CH*SAMPLE_W-1:0]   words_nx
);
  logic [NUM_CH*SAMPLE_W-1:0] conv;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (OFFSET_MASK[c]) begin : g_offset
      // two's complement to offset binary: flip the sign bit
      assign conv[c*SAMPLE_W +: SAMPLE_W] =
        {~words_in[c*SAMPLE_W + SAMPLE_W - 1], words_in[c*SAMPLE_W +: SAMPLE_W-1]};
    end else begin : g_plain
      assign conv[c*SAMPLE_W +: SAMPLE_W] = words_in[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  assign words_nx = load ? conv : words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    words_q <= '0;
    else if (load) words_q <= words_nx;
  end
endmodule

// File: rtl/dac_part_mux.sv
module dac_part_mux #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int BUS_W    = 8,
  parameter int PART_W   = 2
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] words,
  input  logic [PART_W-1:0]          part,
  output logic [BUS_W-1:0]           byte_out
);
  localparam int HI_W = SAMPLE_W - BUS_W;

  logic [SAMPLE_W-1:0] word_sel;
  logic [HI_W-1:0]     hi_bits;

  always_comb begin
    word_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(part[PART_W-1:1]) == c) word_sel = words[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  assign hi_bits  = word_sel[SAMPLE_W-1:BUS_W];
  assign byte_out = part[0] ? {{(BUS_W-HI_W){1'b0}}, hi_bits} : word_sel[BUS_W-1:0];
endmodule

// File: rtl/dac_pair_sequencer.sv
module dac_pair_sequencer
  import dac_seq_pkg::*;
#(
  parameter int         SAMPLE_W    = 12,
  parameter int         BUS_W       = 8,
  parameter int         SETUP_CYC   = 1,
  parameter int         STROBE_CYC  = 1,
  parameter int         HOLD_CYC    = 1,
  parameter logic [1:0] OFFSET_MASK = 2'b10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] ch0_word,
  input  logic [SAMPLE_W-1:0] ch1_word,
  output logic [BUS_W-1:0]    dac_data,
  output logic                dac_a1,
  output logic                dac_a0,
  output logic                dac_cs_n,
  output logic                dac_ldac_n,
  output logic                busy
);
  localparam int NUM_CH    = 2;
  localparam int NUM_PARTS = 2 * NUM_CH;
  localparam int PART_W    = $clog2(NUM_PARTS);
  localparam int LOAD_CYC  = 1;
  localparam int MAX_CYC   = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [PART_W-1:0] LAST_PART = PART_W'(NUM_PARTS - 1);

  logic rst_sync_n;

  seq_state_e        state_q, state_d;
  logic [PART_W-1:0] part_q, part_d;
  logic [CNT_W-1:0]  len_m1;
  logic              tmr_done, tmr_restart;
  logic              accept;

  logic [NUM_CH*SAMPLE_W-1:0] words_q, words_nx;
  logic [BUS_W-1:0]           mux_byte;

  logic [BUS_W-1:0]  data_q, data_d;
  logic [PART_W-1:0] addr_q, addr_d;
  logic              cs_n_q, cs_n_d, ldac_n_q, ldac_n_d, busy_q, busy_d;

  dac_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP: len_m1 = CNT_W'(SETUP_CYC - 1);
      ST_STRB:  len_m1 = CNT_W'(STROBE_CYC - 1);
      ST_HOLD:  len_m1 = CNT_W'(HOLD_CYC - 1);
      ST_LOAD:  len_m1 = CNT_W'(LOAD_CYC - 1);
      default:  len_m1 = '0;
    endcase
  end

  dac_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (tmr_restart),
    .len_m1  (len_m1),
    .done    (tmr_done)
  );

  // strobe is taken when idle, or in the final cycle of the load pulse
  assign accept = frame_stb &&
                  ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && tmr_done));

  dac_word_latch #(
    .NUM_CH      (NUM_CH),
    .SAMPLE_W    (SAMPLE_W),
    .OFFSET_MASK (OFFSET_MASK)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .words_in ({ch1_word, ch0_word}),
    .words_q  (words_q),
    .words_nx (words_nx)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    part_d  = part_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          part_d  = '0;
        end
      end
      ST_SETUP: if (tmr_done) state_d = ST_STRB;
      ST_STRB:  if (tmr_done) state_d = ST_HOLD;
      ST_HOLD: begin
        if (tmr_done) begin
          if (part_q == LAST_PART) begin
            state_d = ST_LOAD;
          end else begin
            state_d = ST_SETUP;
            part_d  = part_q + 1'b1;
          end
        end
      end
      ST_LOAD: begin
        if (tmr_done) begin
          part_d  = '0;
          state_d = accept ? ST_SETUP : ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        part_d  = '0;
      end
    endcase
  end

  assign tmr_restart = (state_d != state_q);

  dac_part_mux #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .BUS_W    (BUS_W),
    .PART_W   (PART_W)
  ) u_mux (
    .words    (words_nx),
    .part     (part_d),
    .byte_out (mux_byte)
  );

  // output next values, registered so pins switch cleanly
  always_comb begin
    cs_n_d   = (state_d != ST_STRB);
    ldac_n_d = (state_d != ST_LOAD);
    busy_d   = (state_d != ST_IDLE);
    addr_d   = (state_d == ST_IDLE) ? '0 : part_d;
    data_d   = (state_d == ST_IDLE) ? '0 : mux_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      part_q   <= '0;
      cs_n_q   <= 1'b1;
      ldac_n_q <= 1'b1;
      busy_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      part_q   <= part_d;
      cs_n_q   <= cs_n_d;
      ldac_n_q <= ldac_n_d;
      busy_q   <= busy_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign dac_data   = data_q;
  assign dac_a1     = addr_q[1];
  assign dac_a0     = addr_q[0];
  assign dac_cs_n   = cs_n_q;
  assign dac_ldac_n = ldac_n_q;
  assign busy       = busy_q;

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] dac_data,
  input logic       dac_a1,
  input logic       dac_a0,
  input logic       dac_cs_n,
  input logic       dac_ldac_n,
  input logic       busy
);
  logic [1:0] addr;
  assign addr = {dac_a1, dac_a0};

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_cs_n && dac_ldac_n));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (addr != $past(addr))) |-> (addr == 2'($past(addr) + 2'd1)));

  p_nibble_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dac_a0) |-> (dac_data[7:4] == 4'h0));

  p_stable_during_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> ($stable(addr) && $stable(dac_data)));

  p_hold_after_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> ($stable(addr) && $stable(dac_data)));

  p_ldac_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ldac_n |=> dac_ldac_n);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dac_cs_n && !dac_ldac_n));

  p_ldac_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ldac_n) |-> (addr == 2'b11 && $past(dac_cs_n)));
endmodule

bind dac_pair_sequencer dac_seq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dac_data   (dac_data),
  .dac_a1     (dac_a1),
  .dac_a0     (dac_a0),
  .dac_cs_n   (dac_cs_n),
  .dac_ldac_n (dac_ldac_n),
  .busy       (busy)
);

// File: tb/tb_dac_pair_sequencer.sv
module tb_dac_pair_sequencer;
  localparam int S_CYC = 1;
  localparam int P_CYC = 1;
  localparam int H_CYC = 1;
  localparam int FRAME = 4 * (S_CYC + P_CYC + H_CYC) + 1;

  logic        clk;
  logic        rst_n;
  logic        frame_stb;
  logic [11:0] ch0_word, ch1_word;
  logic [7:0]  dac_data;
  logic        dac_a1, dac_a0, dac_cs_n, dac_ldac_n, busy;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  dac_pair_sequencer #(
    .SETUP_CYC (S_CYC), .STROBE_CYC (P_CYC), .HOLD_CYC (H_CYC)
  ) dut (
    .clk (clk), .rst_n (rst_n), .frame_stb (frame_stb),
    .ch0_word (ch0_word), .ch1_word (ch1_word),
    .dac_data (dac_data), .dac_a1 (dac_a1), .dac_a0 (dac_a0),
    .dac_cs_n (dac_cs_n), .dac_ldac_n (dac_ldac_n), .busy (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // channel 1 is offset binary: add 2048 to the signed code
  function automatic logic [11:0] code_of(input int ch, input logic [11:0] w);
    int v;
    v = int'(w);
    if (ch == 1) v = (v + 2048) % 4096;
    return 12'(v);
  endfunction

  function automatic logic [7:0] piece(input int p, input logic [11:0] w0, input logic [11:0] w1);
    logic [11:0] c;
    c = (p < 2) ? code_of(0, w0) : code_of(1, w1);
    if (p % 2 == 1) return {4'h0, c[11:8]};
    return c[7:0];
  endfunction

  // reference model: tuple {busy, ldac_n, cs_n, addr[1:0], data[7:0]}
  logic [12:0] exp_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
    end else if (frame_stb && exp_q.size() == 0) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] b;
        b = piece(p, ch0_word, ch1_word);
        for (int i = 0; i < S_CYC; i++) exp_q.push_back({1'b1, 1'b1, 1'b1, 2'(p), b});
        for (int i = 0; i < P_CYC; i++) exp_q.push_back({1'b1, 1'b1, 1'b0, 2'(p), b});
        for (int i = 0; i < H_CYC; i++) exp_q.push_back({1'b1, 1'b1, 1'b1, 2'(p), b});
        if (p == 3) exp_q.push_back({1'b1, 1'b0, 1'b1, 2'(p), b});
      end
    end
  end

  logic [9:0] wr_q[$];
  logic       prev_cs_n = 1'b1;
  int         busy_low_cycles = 0;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      logic [12:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : {1'b0, 1'b1, 1'b1, 2'b00, 8'h00};
      check("R2 busy",        int'(busy),                int'(e[12]));
      check("R6 ldac_n",      int'(dac_ldac_n),          int'(e[11]));
      check("R5 cs_n",        int'(dac_cs_n),            int'(e[10]));
      check("R3 addr",        int'({dac_a1, dac_a0}),    int'(e[9:8]));
      check("R4 data",        int'(dac_data),            int'(e[7:0]));
      if (!dac_cs_n && prev_cs_n) wr_q.push_back({dac_a1, dac_a0, dac_data});
      if (!busy) busy_low_cycles++;
    end
    prev_cs_n = dac_cs_n;
  end

  task automatic strobe(input logic [11:0] w0, input logic [11:0] w1);
    ch0_word  = w0;
    ch1_word  = w1;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic check_writes(input string tag, input int base,
                              input logic [11:0] w0, input logic [11:0] w1);
    for (int p = 0; p < 4; p++) begin
      if (wr_q.size() > base + p) begin
        check(tag, int'(wr_q[base + p]), int'({2'(p), piece(p, w0, w1)}));
      end else begin
        check(tag, -1, int'({2'(p), piece(p, w0, w1)}));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; ch0_word = '0; ch1_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cs_n",   int'(dac_cs_n),   1);
    check("R1 ldac_n", int'(dac_ldac_n), 1);
    check("R1 busy",   int'(busy),       0);
    check("R1 addr",   int'({dac_a1, dac_a0}), 0);
    check("R1 data",   int'(dac_data),   0);

    // R3 R4 R8: basic frame
    wr_q.delete();
    strobe(12'hABC, 12'h123);
    wait_idle();
    check("R3 count", wr_q.size(), 4);
    check_writes("R3 R8 frame", 0, 12'hABC, 12'h123);

    // R8: signed extremes on channel 1
    foreach (wr_q[i]) ; wr_q.delete();
    strobe(12'h000, 12'hFFF);   // -1 -> 0x7FF
    wait_idle();
    check_writes("R8 minus one", 0, 12'h000, 12'hFFF);
    wr_q.delete();
    strobe(12'hFFF, 12'h800);   // -2048 -> 0x000
    wait_idle();
    check_writes("R8 most negative", 0, 12'hFFF, 12'h800);
    wr_q.delete();
    strobe(12'h5A5, 12'h7FF);   // +2047 -> 0xFFF
    wait_idle();
    check_writes("R8 most positive", 0, 12'h5A5, 12'h7FF);

    // R7: strobe mid-frame is ignored
    wr_q.delete();
    strobe(12'h321, 12'h654);
    repeat (3) @(negedge clk);
    strobe(12'hEEE, 12'hDDD);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R7 count", wr_q.size(), 4);
    check_writes("R7 ignored strobe", 0, 12'h321, 12'h654);

    // R9: inputs change right after capture
    wr_q.delete();
    ch0_word = 12'h0F0; ch1_word = 12'hF0F; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0; ch0_word = 12'h999; ch1_word = 12'h111;
    wait_idle();
    check_writes("R9 late input change", 0, 12'h0F0, 12'hF0F);

    // R10: strobe held high across a frame -> restart in load cycle
    wr_q.delete();
    busy_low_cycles = 0;
    ch0_word = 12'h246; ch1_word = 12'h8AC; frame_stb = 1'b1;
    @(negedge clk);
    ch0_word = 12'h135; ch1_word = 12'h79B;
    repeat (FRAME) @(negedge clk);
    frame_stb = 1'b0;
    wait_idle();
    check("R10 no idle gap", busy_low_cycles, 1);
    check("R10 count", wr_q.size(), 8);
    check_writes("R10 first frame", 0, 12'h246, 12'h8AC);
    check_writes("R10 second frame", 4, 12'h135, 12'h79B);

    // pattern sweep
    begin
      logic [11:0] a, b;
      a = 12'h001; b = 12'h800;
      for (int k = 0; k < 20; k++) begin
        wr_q.delete();
        strobe(a, b);
        wait_idle();
        check_writes("R3 sweep", 0, a, b);
        a = {a[10:0], a[11] ^ a[5] ^ a[3] ^ a[0]};
        b = b + 12'h1F3;
        repeat (k % 3) @(negedge clk);
      end
    end

    repeat (5) @(negedge clk);
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule